// File: doc/BRIEF.md
# Three-Channel Dual-Compare Timer

The block holds three 16-bit up-counters that share one update path. A free-running slot counter gives each counter one update opportunity in every group of four clocks (slots 0, 1 and 2 belong to counters 0, 1 and 2; slot 3 is idle), so no counter advances faster than a quarter of the clock rate. Counters 0 and 1 each own an input pin, usable as a count clock or as a gate, and an output pin. Counter 2 has no pins and can supply the count pulses for the other two.

Each counter advances until the next value would equal its active limit, then returns to zero. This is its terminal count. At terminal count it sets a sticky flag and, if allowed, pulses an interrupt line. Counters 0 and 1 can alternate between a first and a second limit. Their output pin then shows which limit is active, which gives a waveform with a programmable duty cycle. A counter either runs continuously or stops itself after one run.

Software reaches the block through a flat register port with combinational read. The address has four bits: bits [3:2] pick the counter and bits [1:0] pick the register (0 value, 1 first limit, 2 second limit, 3 control). Control bits:

| Bit | Meaning |
| --- | --- |
| 0 | run |
| 1 | repeat |
| 2 | alternate |
| 3 | pin-clock |
| 4 | chain-to-counter-2 |
| 5 | gate |
| 6 | interrupt-allow |
| 7 | sticky terminal flag |
| 8 | read-only; 1 when the second limit is active |

Top module: `tmr_unit`

## Requirements
- R1: After reset every counter value, limit and control register reads 0, both output pins are 1 and all interrupt lines are 0.
- R2: With run=1 and bits 3 to 5 all 0, the counter steps once per four clocks and reaches terminal count every 4*L clocks for a limit L of 1 or more. At terminal count the value returns to 0.
- R3: A limit of 0 means a period of 65536 steps: from value 0xFFFF the next step is a terminal count and the value becomes 0.
- R4: With alternate=1 (counters 0 and 1), the limits swap at each terminal count. The output pin is 1 while the first limit is active, for 4*A clocks, and 0 while the second is active, for 4*B clocks.
- R5: With repeat=0, the run bit clears itself at terminal count. With alternate=1 as well, it clears only at the terminal count that ends the second-limit phase.
- R6: With pin-clock=1, each rising edge on the counter's input pin, after a two-flop synchronizer, makes exactly one step.
- R7: With gate=1 and pin-clock=0, the counter steps only while the synchronized input is 1. While the input is 0 the value holds.
- R8: With chain-to-counter-2=1, counter 0 or 1 steps once per terminal count of counter 2, so its period is 4*L2*L clocks.
- R9: Terminal count always sets control bit 7. It raises that counter's interrupt line for exactly one clock only when bit 6 is 1. Software clears bit 7 by writing 0 to it.
- R10: A control write in the same clock as a terminal count of that counter leaves bit 7 set. The terminal count wins over the write's 0.
- R11: With alternate=0, the output pin goes to 0 for the 4 clocks that follow each terminal count and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address {counter, register} |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| tin | input | 2 | Input pins of counters 0 and 1 |
| tout | output | 2 | Output pins of counters 0 and 1 |
| irq | output | 3 | One-clock terminal-count interrupt per counter |

## Verification
A software write to the control register can land in the same clock as a terminal count of that counter. Both try to drive the sticky flag, one to 0 and the other to 1. The bench first finds the terminal-count rhythm of counter 0 from its interrupt pulses, with limit 2 giving 8 clocks. It then times a control write with the flag bit at 0 so the write is captured exactly on the next terminal-count edge. It checks that the interrupt fired and that the flag reads 1 afterwards. The same write placed two clocks later, off the terminal count, must clear the flag, which shows the first result comes from the collision.

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [3:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [1:0]   tin,
  output logic [1:0]   tout,
  output logic [2:0]   irq
);

  localparam int NT = 3;

  logic [1:0]   slot;
  logic [1:0]   s1, s2, s3;
  logic [1:0]   edge_p, pre_p;
  logic [W-1:0] cnt [NT];
  logic [W-1:0] mxa [NT];
  logic [W-1:0] mxb [NT];
  logic [7:0]   ctl [NT];
  logic [2:0]   actb, pls;

  logic [W-1:0] mx  [NT];
  logic [W-1:0] nxt [NT];
  logic [2:0]   ev, run, tc;
  logic [2:0]   sy, ep, pp;

  assign sy = {1'b0, s2};
  assign ep = {1'b0, edge_p | (s2 & ~s3)};
  assign pp = {1'b0, pre_p};

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      mx[i]  = (ctl[i][2] && actb[i]) ? mxb[i] : mxa[i];
      ev[i]  = ctl[i][4] ? pp[i] : ctl[i][3] ? ep[i] : (!ctl[i][5] || sy[i]);
      run[i] = (slot == 2'(i)) && ctl[i][0] && ev[i];
      nxt[i] = cnt[i] + 1'b1;
      tc[i]  = run[i] && (nxt[i] == mx[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0; s1 <= '0; s2 <= '0; s3 <= '0;
      edge_p <= '0; pre_p <= '0;
      actb <= '0; pls <= '0; irq <= '0;
      for (int i = 0; i < NT; i++) begin
        cnt[i] <= '0; mxa[i] <= '0; mxb[i] <= '0; ctl[i] <= '0;
      end
    end else begin
      slot <= slot + 2'd1;
      s1 <= tin; s2 <= s1; s3 <= s2;
      for (int i = 0; i < 2; i++) begin
        edge_p[i] <= (slot == 2'(i)) ? 1'b0 : (edge_p[i] | (s2[i] & ~s3[i]));
        pre_p[i]  <= (slot == 2'(i)) ? 1'b0 : (pre_p[i] | tc[2]);
      end
      for (int i = 0; i < NT; i++) begin
        irq[i] <= tc[i] & ctl[i][6];
        if (slot == 2'(i)) pls[i] <= tc[i];
        if (run[i]) cnt[i] <= tc[i] ? '0 : nxt[i];
        if (tc[i]) begin
          ctl[i][7] <= 1'b1;
          if (ctl[i][2]) actb[i] <= ~actb[i];
          if (!ctl[i][1] && (!ctl[i][2] || actb[i])) ctl[i][0] <= 1'b0;
        end
        if (wr_en && addr[3:2] == 2'(i)) begin
          case (addr[1:0])
            2'd0: cnt[i] <= wdata;
            2'd1: mxa[i] <= wdata;
            2'd2: if (i < 2) mxb[i] <= wdata;
            default: begin
              ctl[i] <= (i < 2) ? wdata[7:0] : (wdata[7:0] & 8'hC3);
              ctl[i][7] <= wdata[7] | tc[i];
              actb[i] <= 1'b0;
              pls[i] <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_pin
    assign tout[g] = ctl[g][2] ? ~actb[g] : ~pls[g];
  end

  always_comb begin
    rdata = '0;
    if (addr[3:2] != 2'd3) begin
      case (addr[1:0])
        2'd0: rdata = cnt[addr[3:2]];
        2'd1: rdata = mxa[addr[3:2]];
        2'd2: rdata = mxb[addr[3:2]];
        default: rdata = {{(W-9){1'b0}}, actb[addr[3:2]], ctl[addr[3:2]]};
      endcase
    end
  end

  // R2
  cnt_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt[0]) |-> ($past(slot) == 2'd0 || $past(wr_en && addr == 4'd0)));

  // R9
  irq_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |-> $past(slot) == 2'd1);

  // R4
  dual_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc[1] && ctl[1][2] && !(wr_en && addr == 4'd7)) |=> actb[1] != $past(actb[1]));

  // R5
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc[0] && !ctl[0][1] && !ctl[0][2] && !(wr_en && addr == 4'd3)) |=> !ctl[0][0]);

  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 2'd0 && ctl[0][5] && !ctl[0][3] && !ctl[0][4] && !s2[0]
     && !(wr_en && addr[3:2] == 2'd0)) |=> $stable(cnt[0]));

endmodule

// File: tb/tmr_unit_bench.sv
module tmr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [1:0] tin = 0, tout;
  logic [2:0] irq;
  int checks = 0, errors = 0;

  tmr_unit u_tmr_unit (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tin(tin), .tout(tout), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, output int d);
    addr = 4'(a); #1; d = int'(rdata);
  endtask

  task automatic wait_irq(int t, output int ok);
    ok = 0;
    for (int j = 0; j < 3000 && ok == 0; j++) begin
      @(negedge clk);
      if (irq[t]) ok = 1;
    end
  endtask

  task automatic irq_period(int t, output int p);
    int ok;
    wait_irq(t, ok);
    p = 0;
    do begin @(negedge clk); p++; end while (!irq[t] && p < 5000);
  endtask

  task automatic count_irq(int t, int n, output int k);
    k = 0;
    repeat (n) begin @(negedge clk); if (irq[t]) k++; end
  endtask

  task automatic setup(int t, int ma, int mb, int c);
    wr(t*4+3, 0); wr(t*4+0, 0); wr(t*4+1, ma);
    if (t < 2) wr(t*4+2, mb);
    wr(t*4+3, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, p, k, h, l, ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 tout", int'(tout), 3);
    check("R1 irq", int'(irq), 0);
    for (int a = 0; a < 12; a++) begin rd(a, v); check("R1 reg", v, 0); end

    // R2 sweep of limits over every counter
    for (int t = 0; t < 3; t++)
      for (int m = 1; m <= 5; m++) begin
        setup(t, m, 0, 'h43);
        irq_period(t, p);
        check("R2 period", p, 4*m);
        wr(t*4+3, 0);
      end

    // R9 one-clock pulse
    setup(0, 3, 0, 'h43);
    wait_irq(0, ok); @(negedge clk);
    check("R9 irq width", int'(irq[0]), 0);
    wr(3, 0);

    // R3 limit zero
    wr(11, 0); wr(8, 'hFFFE); wr(9, 0); wr(11, 'h43);
    wait_irq(2, ok);
    check("R3 tc seen", ok, 1);
    rd(8, v); check("R3 wrap", v, 0);
    wr(11, 0);

    // R4 alternating limits
    for (int b = 1; b <= 3; b++) begin
      setup(1, 3, b, 'h07);
      while (tout[1] == 1) @(negedge clk);
      while (tout[1] == 0) @(negedge clk);
      h = 0; while (tout[1] == 1 && h < 500) begin h++; @(negedge clk); end
      l = 0; while (tout[1] == 0 && l < 500) begin l++; @(negedge clk); end
      check("R4 high", h, 12);
      check("R4 low", l, 4*b);
    end
    wr(7, 0);

    // R11 pulse output
    setup(0, 3, 0, 'h03);
    while (tout[0] == 1) @(negedge clk);
    l = 0; while (tout[0] == 0 && l < 500) begin l++; @(negedge clk); end
    h = 0; while (tout[0] == 1 && h < 500) begin h++; @(negedge clk); end
    check("R11 low", l, 4);
    check("R11 high", h, 8);
    wr(3, 0);

    // R5 single run
    setup(1, 2, 0, 'h41);
    wait_irq(1, ok); repeat (2) @(negedge clk);
    rd(7, v); check("R5 run cleared, flag set", v & 'h81, 'h80);
    count_irq(1, 40, k); check("R5 stays stopped", k, 0);
    setup(1, 2, 3, 'h45);
    count_irq(1, 80, k); check("R5 dual runs A then B", k, 2);
    rd(7, v); check("R5 dual run cleared", v & 1, 0);

    // R6 pin clock
    setup(1, 3, 0, 'h49);
    repeat (20) @(negedge clk);
    rd(4, v); check("R6 no edges", v, 0);
    repeat (2) begin
      tin[1] = 1; repeat (3) @(negedge clk); tin[1] = 0; repeat (7) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    rd(4, v); check("R6 two edges", v, 2);
    tin[1] = 1; repeat (3) @(negedge clk); tin[1] = 0;
    count_irq(1, 12, k); check("R6 third edge tc", k, 1);
    rd(4, v); check("R6 wrap", v, 0);
    wr(7, 0);

    // R7 gate
    setup(0, 1000, 0, 'h23);
    repeat (40) @(negedge clk);
    rd(0, v); check("R7 gate low holds", v, 0);
    tin[0] = 1; repeat (40) @(negedge clk);
    rd(0, v); check("R7 gate high counts", int'(v >= 8 && v <= 11), 1);
    tin[0] = 0; repeat (10) @(negedge clk);
    rd(0, h); repeat (40) @(negedge clk); rd(0, v);
    check("R7 gate closed again", v, h);
    wr(3, 0);

    // R8 chained to counter 2
    setup(2, 2, 0, 'h03); setup(0, 3, 0, 'h53);
    irq_period(0, p); check("R8 period 2x3", p, 24);
    wr(3, 0); wr(11, 0);
    setup(2, 1, 0, 'h03); setup(0, 5, 0, 'h53);
    irq_period(0, p); check("R8 period 1x5", p, 20);
    wr(3, 0);

    // R9 interrupt disabled, flag still set, then cleared
    setup(2, 2, 0, 'h03);
    count_irq(2, 30, k); check("R9 no irq when disallowed", k, 0);
    wr(11, 0);
    rd(11, v); check("R9 flag cleared by write", v & 'h80, 0);
    setup(2, 2, 0, 'h03);
    repeat (30) @(negedge clk);
    rd(11, v); check("R9 flag set", v & 'h80, 'h80);
    wr(11, 0);

    // R10 write collides with terminal count
    setup(0, 2, 0, 'h43);
    wait_irq(0, ok);
    repeat (7) @(negedge clk);
    wr(3, 'h43);
    check("R10 tc on write edge", int'(irq[0]), 1);
    rd(3, v); check("R10 flag kept", v & 'h80, 'h80);
    @(negedge clk);
    wr(3, 'h43);
    rd(3, v); check("R10 off-tc write clears", v & 'h80, 0);
    wr(3, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule